// File: doc/BRIEF.md
# Double to Modular Int32 Converter

This block turns an IEEE-754 double-precision operand into a 32-bit signed integer. It truncates toward zero. Values that do not fit in 32 bits are not clamped. The result is the low 32 bits of the truncated integer in two's complement, so it wraps modulo 2^32 the way scripting-language integer coercion does. Each operation also produces three exception pulses (invalid, inexact, input-denormal) and a four-bit condition nibble. Only the Z bit of that nibble is ever set, and it is set when the conversion was exact.

The conversion logic is purely combinational. A single register stage follows it. An operand is presented together with a one-cycle valid strobe and a flush-subnormal-inputs control, and the answer appears exactly one clock later, qualified by an output valid. Unlike the IEEE view, a negative zero counts as not exact here: it clears Z but raises no flag.

Top module: `dm32_cvt`

## Requirements
- R1: The operand is split into sign at bit 63, an 11-bit biased exponent (bias 1023) at bits 62..52 and a 52-bit fraction at bits 51..0. A normal operand whose truncated value lies in [-2^31, 2^31-1] with no fractional part returns that value, raises no flag, and sets Z.
- R2: A normal operand with a nonzero fractional part whose truncated value is in range returns the value truncated toward zero, raises inexact, and clears Z.
- R3: An operand with exponent and fraction both zero returns 0 and raises no flag. Z is 1 for +0 and 0 for -0.
- R4: A subnormal operand (exponent zero, fraction nonzero) converted with flush high returns 0 and raises only input-denormal. Z follows the sign as in R3.
- R5: A subnormal operand converted with flush low returns 0, raises only inexact, and clears Z.
- R6: An operand with an all-ones exponent (infinity or NaN) returns 0, raises only invalid, and clears Z, whatever the flush control is.
- R7: Overflow occurs when the unbiased exponent exceeds 31, or the truncated magnitude exceeds 2^31-1 for a positive operand or 2^31 for a negative one. It raises invalid but not inexact, clears Z, and returns the low 32 bits of the two's-complement truncated value (the modulo-2^32 wrap).
- R8: A normal operand with magnitude below 1, including one so small that every significand bit is shifted out, returns 0, raises inexact, and clears Z.
- R9: The condition nibble is {N,Z,C,V} with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. N, C and V are always 0.
- R10: out_valid is high exactly one cycle after in_valid. The result and nibble load only on a valid operand and otherwise hold. The flag outputs are 0 whenever out_valid is low.
- R11: Reset drives out_valid, the result, all flags and the nibble to zero.
- R12: An operand whose significand would move 64 or more places left (for example 2^200) returns 0 and raises invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Double-precision operand |
| in_flush | input | 1 | Treat subnormal inputs as zero and flag them |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Wrapped, truncated integer |
| out_invalid | output | 1 | Invalid pulse (special operand or overflow) |
| out_inexact | output | 1 | Inexact pulse (bits lost without overflow) |
| out_denorm | output | 1 | Input-denormal pulse (flushed subnormal) |
| out_nzcv | output | 4 | Condition nibble, Z set on exact conversion |

## Verification
The checker properties assume that rst_n is released with in_valid low, and that in_op and in_flush only matter in a cycle where in_valid is high. The properties that look at operand classes sample in_op in the valid cycle and compare it with the registered outputs one clock later. The directed stimulus changes every input on the falling clock edge, keeps in_valid low throughout reset, and builds each operand either from a real literal or from an explicit bit pattern. The operand set covers both zeros, subnormals of both signs under both flush settings, infinity and NaN, and the exact 32-bit limits and the values just past them.

// File: rtl/dm32_pkg.sv
package dm32_pkg;
   localparam int DEF_EXP_W  = 11;
   localparam int DEF_FRAC_W = 52;
   localparam int DEF_RES_W  = 32;

   typedef enum logic [1:0] {
      CLS_ZERO    = 2'd0,
      CLS_SPECIAL = 2'd1,
      CLS_NORMAL  = 2'd2
   } dm_cls_e;

   typedef struct packed {
      logic invalid;
      logic inexact;
      logic denorm;
   } dm_flags_t;
endpackage

// File: rtl/dm32_unpack.sv
module dm32_unpack
   import dm32_pkg::*;
#(
   parameter int EXP_W  = DEF_EXP_W,
   parameter int FRAC_W = DEF_FRAC_W,
   localparam int OP_W  = 1 + EXP_W + FRAC_W,
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
   input  logic [OP_W-1:0]   op_i,
   output logic              sign_o,
   output dm_cls_e           cls_o,
   output logic              frac_nz_o,
   output logic [FRAC_W:0]   sig_o,
   output int                texp_o,
   output int                shift_o
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign sign_o    = op_i[OP_W-1];
   assign exp_f     = op_i[OP_W-2 -: EXP_W];
   assign frac_f    = op_i[FRAC_W-1:0];
   assign frac_nz_o = |frac_f;
   assign sig_o     = {1'b1, frac_f};
   assign texp_o    = int'(exp_f) - BIAS;
   assign shift_o   = texp_o - FRAC_W;

   always_comb begin
      if (exp_f == '0)
         cls_o = CLS_ZERO;
      else if (&exp_f)
         cls_o = CLS_SPECIAL;
      else
         cls_o = CLS_NORMAL;
   end
endmodule

// File: rtl/dm32_align.sv
module dm32_align #(
   parameter int  FRAC_W  = 52,
   parameter int  WIDE_W  = 64,
   parameter bit  LOG_SHIFT = 1'b1,
   localparam int SHW     = $clog2(WIDE_W)
) (
   input  logic [FRAC_W:0]   sig_i,
   input  int                shift_i,
   output logic [WIDE_W-1:0] mag_o,
   output logic              lost_o
);
   logic [WIDE_W-1:0] wide_sig;
   logic [SHW-1:0]    ramt;
   logic [SHW-1:0]    lamt;
   logic [WIDE_W-1:0] rsh_val;
   logic              rsh_lost;

   assign wide_sig = WIDE_W'(sig_i);
   assign ramt     = SHW'(-shift_i);
   assign lamt     = SHW'(shift_i);

   generate
      if (LOG_SHIFT) begin : g_log
         logic [WIDE_W-1:0] stage_v [SHW+1];
         logic              stage_s [SHW+1];
         assign stage_v[0] = wide_sig;
         assign stage_s[0] = 1'b0;
         for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage_v[k+1] = ramt[k] ? (stage_v[k] >> STEP) : stage_v[k];
            assign stage_s[k+1] = stage_s[k] | (ramt[k] & (|stage_v[k][STEP-1:0]));
         end
         assign rsh_val  = stage_v[SHW];
         assign rsh_lost = stage_s[SHW];
      end else begin : g_flat
         logic [WIDE_W-1:0] keep_mask;
         assign keep_mask = ~({WIDE_W{1'b1}} << ramt);
         assign rsh_val   = wide_sig >> ramt;
         assign rsh_lost  = |(wide_sig & keep_mask);
      end
   endgenerate

   always_comb begin
      if (shift_i >= 0) begin
         mag_o  = (shift_i >= WIDE_W) ? '0 : (wide_sig << lamt);
         lost_o = 1'b0;
      end else if (shift_i > -WIDE_W) begin
         mag_o  = rsh_val;
         lost_o = rsh_lost;
      end else begin
         mag_o  = '0;
         lost_o = 1'b1;
      end
   end
endmodule

// File: rtl/dm32_wrap.sv
module dm32_wrap
   import dm32_pkg::*;
#(
   parameter int RES_W  = DEF_RES_W,
   parameter int WIDE_W = 2 * DEF_RES_W
) (
   input  dm_cls_e           cls_i,
   input  logic              sign_i,
   input  logic              frac_nz_i,
   input  logic              flush_i,
   input  int                texp_i,
   input  logic [WIDE_W-1:0] mag_i,
   input  logic              lost_i,
   output logic [RES_W-1:0]  res_o,
   output dm_flags_t         flags_o,
   output logic              exact_o
);
   localparam logic [WIDE_W-1:0] LIM_NEG = WIDE_W'(1) << (RES_W - 1);
   localparam logic [WIDE_W-1:0] LIM_POS = LIM_NEG - WIDE_W'(1);

   logic              ovf;
   logic [WIDE_W-1:0] signed_mag;

   assign ovf        = (texp_i > RES_W - 1) || (mag_i > (sign_i ? LIM_NEG : LIM_POS));
   assign signed_mag = sign_i ? (~mag_i + WIDE_W'(1)) : mag_i;

   always_comb begin
      flags_o = '0;
      res_o   = '0;
      exact_o = 1'b0;
      unique case (cls_i)
         CLS_ZERO: begin
            exact_o = ~sign_i;
            if (frac_nz_i) begin
               if (flush_i) begin
                  flags_o.denorm = 1'b1;
               end else begin
                  flags_o.inexact = 1'b1;
                  exact_o         = 1'b0;
               end
            end
         end
         CLS_SPECIAL: begin
            flags_o.invalid = 1'b1;
         end
         CLS_NORMAL: begin
            res_o = signed_mag[RES_W-1:0];
            if (ovf) begin
               flags_o.invalid = 1'b1;
            end else begin
               flags_o.inexact = lost_i;
               exact_o         = ~lost_i;
            end
         end
         default: begin
            flags_o.invalid = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/dm32_cvt.sv
module dm32_cvt
   import dm32_pkg::*;
#(
   parameter int  EXP_W     = DEF_EXP_W,
   parameter int  FRAC_W    = DEF_FRAC_W,
   parameter int  RES_W     = DEF_RES_W,
   parameter bit  LOG_SHIFT = 1'b1,
   localparam int OP_W      = 1 + EXP_W + FRAC_W,
   localparam int WIDE_W    = 2 * RES_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_op,
   input  logic              in_flush,
   output logic              out_valid,
   output logic [RES_W-1:0]  out_result,
   output logic              out_invalid,
   output logic              out_inexact,
   output logic              out_denorm,
   output logic [3:0]        out_nzcv
);
   generate
      if (EXP_W < 2 || EXP_W > 15)
         $error("dm32_cvt: EXP_W out of supported range");
      if (RES_W < 2)
         $error("dm32_cvt: RES_W too small");
      if (FRAC_W + 1 > WIDE_W)
         $error("dm32_cvt: significand wider than work width");
   endgenerate

   logic              sign;
   dm_cls_e           cls;
   logic              frac_nz;
   logic [FRAC_W:0]   sig;
   int                texp;
   int                shift;
   logic [WIDE_W-1:0] mag;
   logic              lost;
   logic [RES_W-1:0]  res_c;
   dm_flags_t         flags_c;
   logic              exact_c;

   dm32_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .op_i      (in_op),
      .sign_o    (sign),
      .cls_o     (cls),
      .frac_nz_o (frac_nz),
      .sig_o     (sig),
      .texp_o    (texp),
      .shift_o   (shift)
   );

   dm32_align #(.FRAC_W(FRAC_W), .WIDE_W(WIDE_W), .LOG_SHIFT(LOG_SHIFT)) u_align (
      .sig_i   (sig),
      .shift_i (shift),
      .mag_o   (mag),
      .lost_o  (lost)
   );

   dm32_wrap #(.RES_W(RES_W), .WIDE_W(WIDE_W)) u_wrap (
      .cls_i     (cls),
      .sign_i    (sign),
      .frac_nz_i (frac_nz),
      .flush_i   (in_flush),
      .texp_i    (texp),
      .mag_i     (mag),
      .lost_i    (lost),
      .res_o     (res_c),
      .flags_o   (flags_c),
      .exact_o   (exact_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_nzcv    <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
         out_denorm  <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_invalid <= in_valid & flags_c.invalid;
         out_inexact <= in_valid & flags_c.inexact;
         out_denorm  <= in_valid & flags_c.denorm;
         if (in_valid) begin
            out_result <= res_c;
            out_nzcv   <= {1'b0, exact_c, 2'b00};
         end
      end
   end
endmodule

module dm32_cvt_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int RES_W  = 32,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [OP_W-1:0]  in_op,
   input logic             in_flush,
   input logic             out_valid,
   input logic [RES_W-1:0] out_result,
   input logic             out_invalid,
   input logic             out_inexact,
   input logic             out_denorm,
   input logic [3:0]       out_nzcv
);
   logic [EXP_W-1:0] exp_f;
   logic             frac_nz;
   assign exp_f   = in_op[OP_W-2 -: EXP_W];
   assign frac_nz = |in_op[FRAC_W-1:0];

   assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_invalid && !out_inexact && !out_denorm);
   assert_nibble_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_nzcv[3] && out_nzcv[1:0] == 2'b00);
   assert_flag_clears_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (out_invalid || out_inexact) |-> !out_nzcv[2]);
   assert_inv_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({out_invalid, out_inexact, out_denorm}) <= 1);
   assert_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (&exp_f) |=> out_invalid && out_result == '0 && !out_nzcv[2]);
   assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && exp_f == '0 && (!frac_nz || in_flush)
      |=> out_result == '0 && out_nzcv[2] == !$past(in_op[OP_W-1]));
   assert_denorm_only_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (exp_f != '0 || !frac_nz || !in_flush) |=> !out_denorm);
endmodule

bind dm32_cvt dm32_cvt_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_op       (in_op),
   .in_flush    (in_flush),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact),
   .out_denorm  (out_denorm),
   .out_nzcv    (out_nzcv)
);

// File: tb/dm32_cvt_tb.sv
`timescale 1ns/1ps
module dm32_cvt_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic        in_flush = 1'b0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_invalid, out_inexact, out_denorm;
   logic [3:0]  out_nzcv;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   dm32_cvt u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_flush(in_flush), .out_valid(out_valid), .out_result(out_result),
      .out_invalid(out_invalid), .out_inexact(out_inexact),
      .out_denorm(out_denorm), .out_nzcv(out_nzcv)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic expect_out(input logic [31:0] er, input logic ei, ex, ed, ez,
                             input string tag);
      chk(out_valid === 1'b1, tag, "out_valid", 64'(out_valid), 64'd1);
      chk(out_result === er, tag, "result", 64'(out_result), 64'(er));
      chk({out_invalid, out_inexact, out_denorm} === {ei, ex, ed}, tag,
          "flags{inv,inx,den}", 64'({out_invalid, out_inexact, out_denorm}),
          64'({ei, ex, ed}));
      chk(out_nzcv === {1'b0, ez, 2'b00}, tag, "nzcv (R9)", 64'(out_nzcv),
          64'({1'b0, ez, 2'b00}));
   endtask

   task automatic run(input logic [63:0] op, input logic fl, input logic [31:0] er,
                      input logic ei, ex, ed, ez, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_flush = fl;
      @(negedge clk);
      in_valid = 1'b0; in_op = '0; in_flush = 1'b0;
      expect_out(er, ei, ex, ed, ez, tag);
   endtask

   function automatic logic [63:0] d(input real r);
      return $realtobits(r);
   endfunction

   task automatic t_reset;
      chk(out_valid === 1'b0 && out_result === '0 && out_nzcv === '0 &&
          {out_invalid, out_inexact, out_denorm} === 3'b000, "R11", "reset state",
          64'({out_valid, out_result, out_nzcv, out_invalid, out_inexact, out_denorm}), 64'd0);
   endtask

   task automatic t_exact;
      run(d(42.0),           1'b0, 32'd42,        0, 0, 0, 1, "R1 +42");
      run(d(-7.0),           1'b0, 32'hFFFF_FFF9, 0, 0, 0, 1, "R1 -7");
      run(d(2147483647.0),   1'b0, 32'h7FFF_FFFF, 0, 0, 0, 1, "R1 max pos");
      run(d(-2147483648.0),  1'b0, 32'h8000_0000, 0, 0, 0, 1, "R7 min neg boundary exact");
   endtask

   task automatic t_fraction;
      run(d(3.75),  1'b0, 32'd3,         0, 1, 0, 0, "R2 +3.75");
      run(d(-3.75), 1'b0, 32'hFFFF_FFFD, 0, 1, 0, 0, "R2 -3.75");
      run(d(3.75),  1'b1, 32'd3,         0, 1, 0, 0, "R2 flush ignored on normal");
   endtask

   task automatic t_small;
      run(d(0.5),    1'b0, 32'd0, 0, 1, 0, 0, "R8 0.5");
      run(d(1e-300), 1'b0, 32'd0, 0, 1, 0, 0, "R8 1e-300 fully shifted out");
   endtask

   task automatic t_zero_sub;
      run(64'h0000_0000_0000_0000, 1'b0, 32'd0, 0, 0, 0, 1, "R3 +0");
      run(64'h8000_0000_0000_0000, 1'b0, 32'd0, 0, 0, 0, 0, "R3 -0");
      run(64'h0000_0000_0000_0001, 1'b1, 32'd0, 0, 0, 1, 1, "R4 +sub flush");
      run(64'h8000_0000_0000_0001, 1'b1, 32'd0, 0, 0, 1, 0, "R4 -sub flush");
      run(64'h000F_FFFF_FFFF_FFFF, 1'b0, 32'd0, 0, 1, 0, 0, "R5 +sub noflush");
      run(64'h8000_0000_0000_0001, 1'b0, 32'd0, 0, 1, 0, 0, "R5 -sub noflush");
   endtask

   task automatic t_special;
      run(64'h7FF0_0000_0000_0000, 1'b0, 32'd0, 1, 0, 0, 0, "R6 +inf");
      run(64'hFFF0_0000_0000_0000, 1'b1, 32'd0, 1, 0, 0, 0, "R6 -inf flush");
      run(64'hFFF8_0000_0000_0001, 1'b0, 32'd0, 1, 0, 0, 0, "R6 NaN");
   endtask

   task automatic t_overflow;
      run(d(2147483648.0),  1'b0, 32'h8000_0000, 1, 0, 0, 0, "R7 2^31");
      run(d(-2147483649.0), 1'b0, 32'h7FFF_FFFF, 1, 0, 0, 0, "R7 -(2^31+1)");
      run(d(3.0e9),         1'b0, 32'hB2D0_5E00, 1, 0, 0, 0, "R7 3e9 wrap");
      run(d(4294967301.0),  1'b0, 32'd5,         1, 0, 0, 0, "R7 2^32+5");
      run(d(-4294967301.0), 1'b0, 32'hFFFF_FFFB, 1, 0, 0, 0, "R7 -(2^32+5)");
      run(d(4294967301.5),  1'b0, 32'd5,         1, 0, 0, 0, "R7 overflow with fraction no inexact");
      run(64'h4C70_0000_0000_0000, 1'b0, 32'd0,  1, 0, 0, 0, "R12 2^200");
   endtask

   task automatic t_timing;
      @(negedge clk);
      in_valid = 1'b1; in_op = d(10.0); in_flush = 1'b0;
      @(negedge clk);
      in_op = d(-0.25);
      expect_out(32'd10, 0, 0, 0, 1, "R10 back-to-back first");
      @(negedge clk);
      in_valid = 1'b0; in_op = d(99.0);
      expect_out(32'd0, 0, 1, 0, 0, "R10 back-to-back second");
      @(negedge clk);
      chk(out_valid === 1'b0, "R10", "valid drops", 64'(out_valid), 64'd0);
      chk(out_result === 32'd0 && out_nzcv === 4'b0000, "R10", "result/nibble hold",
          64'({out_result, out_nzcv}), 64'd0);
      chk({out_invalid, out_inexact, out_denorm} === 3'b000, "R10", "flags quiet",
          64'({out_invalid, out_inexact, out_denorm}), 64'd0);
      run(d(5.0), 1'b0, 32'd5, 0, 0, 0, 1, "R10 single");
      @(negedge clk);
      chk(out_valid === 1'b0 && out_result === 32'd5 && out_nzcv === 4'b0100, "R10",
          "idle hold", 64'({out_valid, out_result, out_nzcv}), 64'({1'b0, 32'd5, 4'b0100}));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_exact();
      t_fraction();
      t_small();
      t_zero_sub();
      t_special();
      t_overflow();
      t_timing();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", n_chk);
      finish_run();
   end
endmodule